// File: doc/BRIEF.md
# Accumulator Register File with Size-Converting Transfers

This block holds a small processor's working registers: two byte-wide accumulators, named A and B, and three word-wide registers, named X, Y and SP. The pair A:B can also be read and written as one word register, D. A is its upper byte and B its lower byte. A combinational read port returns any register selected by a 3-bit code.

An operation port performs one of four actions on the clock edge where `op_valid` is high:

- a load of `wr_data` into a register;
- a generic move between two registers;
- an exchange of two registers;
- a flag-producing byte copy between A and B.

Moves and exchanges convert sizes. A byte going into a word register is sign-extended. A word going into a byte register keeps only its low byte.

Every operation is answered one cycle later by exactly one pulse: `op_done` if the operation was accepted, or `op_err` if it was rejected. A rejected operation changes nothing. The flag strobe tells the surrounding core to load N and Z from `flag_n`/`flag_z` and to clear V. It fires only for the A/B flag copy.

Top module: `regbank_xfer`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register becomes zero and `op_done`, `op_err` and `flag_upd` are low after that edge.
- R2: Select codes are A=0, B=1, D=3, X=4, Y=5, SP=7. A load (op_kind 0) into A or B stores `wr_data[7:0]`. A load into D stores `wr_data[15:8]` in A and `wr_data[7:0]` in B. A load into X, Y or SP stores all 16 bits.
- R3: `rd_data` returns {A,B} for code 3, the zero-extended byte for codes 0 and 1, the full word for codes 4, 5 and 7, and zero for codes 2 and 6.
- R4: A move (op_kind 1) between two word registers copies all 16 bits into `op_dst` and leaves `op_src` unchanged.
- R5: A move from A or B into a word register writes the source byte sign-extended to 16 bits.
- R6: A move from a word register into A or B writes bits 7..0 of the source word.
- R7: An exchange (op_kind 2) swaps the two registers. When the sizes differ, the word register receives the sign-extended old byte and the byte register receives the low byte of the old word.
- R8: An operation is rejected in any of these cases. The rejection raises `op_err` one cycle later, does not raise `op_done`, and leaves every register unchanged.
  - It names code 2 or 6 in a field it uses.
  - It is an exchange between D and A or B.
  - It is a flag copy whose pair is not A-to-B or B-to-A.
- R9: Every clock edge with `op_valid` high produces exactly one of `op_done` or `op_err` in the following cycle. An edge with `op_valid` low produces neither.
- R10: A flag copy (op_kind 3, with `op_src`/`op_dst` equal to A/B or B/A) copies the byte and raises `flag_upd` together with `op_done`. It sets `flag_n` to bit 7 of the byte and `flag_z` high when the byte is zero. Loads, moves and exchanges never raise `flag_upd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Perform the operation on this edge |
| op_kind | input | 2 | 0 load, 1 move, 2 exchange, 3 flag copy |
| op_dst | input | 3 | Destination register code |
| op_src | input | 3 | Source register code (move, exchange, flag copy) |
| wr_data | input | 16 | Load value |
| rd_sel | input | 3 | Read port register code |
| rd_data | output | 16 | Read port value |
| op_done | output | 1 | Accepted operation completed (one-cycle pulse) |
| op_err | output | 1 | Rejected operation (one-cycle pulse) |
| flag_upd | output | 1 | Load N and Z from the flag outputs and clear V |
| flag_n | output | 1 | Negative flag of the last flag copy |
| flag_z | output | 1 | Zero flag of the last flag copy |

## Verification
The assertions assume that `op_kind`, `op_dst`, `op_src` and `wr_data` are known whenever `op_valid` is high. They also assume the inputs change only away from the rising edge.

The bench drives every input at the falling edge. It holds `op_valid` low between operations, so each operation's answer and register effect are observed in isolation. The register codes are drawn uniformly over all eight values, so invalid codes and rejected exchange pairs occur naturally next to the directed corner cases.

// File: rtl/regbank_pkg.sv
// Shared codes for the accumulator register file.
// Assumes a 3-bit register select; codes 2 and 6 are unused.
package regbank_pkg;
    localparam int SEL_W = 3;
    typedef logic [SEL_W-1:0] sel_t;

    localparam sel_t SEL_A  = 3'd0;
    localparam sel_t SEL_B  = 3'd1;
    localparam sel_t SEL_D  = 3'd3;
    localparam sel_t SEL_X  = 3'd4;
    localparam sel_t SEL_SP = 3'd7;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_MOVE  = 2'd1,
        OP_SWAP  = 2'd2,
        OP_FCOPY = 2'd3
    } op_kind_e;

    // True when the code names an existing register.
    function automatic logic code_ok(sel_t c);
        return (c != 3'd2) && (c != 3'd6);
    endfunction

    // True when the code names a byte accumulator.
    function automatic logic code_is_byte(sel_t c);
        return (c == SEL_A) || (c == SEL_B);
    endfunction
endpackage

// File: rtl/regbank_decode.sv
// Operation decoder: decides whether an operation is legal.
// Assumes inputs are stable while op_valid is sampled; purely combinational.
module regbank_decode
    import regbank_pkg::*;
(
    input  logic [1:0] op_kind,
    input  logic [2:0] op_dst,
    input  logic [2:0] op_src,
    output logic       accept,
    output logic       dst_byte,
    output logic       src_byte
);
    logic mixed_d;

    // Classify operand sizes and spot exchanges that overlap D with A/B.
    always_comb begin
        dst_byte = code_is_byte(op_dst);
        src_byte = code_is_byte(op_src);
        mixed_d  = ((op_dst == SEL_D) && src_byte) || ((op_src == SEL_D) && dst_byte);
    end

    // Legality per operation kind.
    always_comb begin
        case (op_kind_e'(op_kind))
            OP_LOAD:  accept = code_ok(op_dst);
            OP_MOVE:  accept = code_ok(op_dst) && code_ok(op_src);
            OP_SWAP:  accept = code_ok(op_dst) && code_ok(op_src) && !mixed_d;
            default:  accept = ((op_dst == SEL_A) && (op_src == SEL_B)) ||
                               ((op_dst == SEL_B) && (op_src == SEL_A));
        endcase
    end
endmodule

// File: rtl/regbank_fit.sv
// Size converter: sign-extends a byte into a word, or truncates a word to
// its low byte. The byte value sits in the low half of val.
module regbank_fit #(
    parameter int BYTE_W = 8
) (
    input  logic [2*BYTE_W-1:0] val,
    input  logic                from_byte,
    input  logic                to_byte,
    output logic [2*BYTE_W-1:0] fit
);
    // Pick the conversion implied by the two operand sizes.
    always_comb begin
        if (to_byte)
            fit = {{BYTE_W{1'b0}}, val[BYTE_W-1:0]};
        else if (from_byte)
            fit = {{BYTE_W{val[BYTE_W-1]}}, val[BYTE_W-1:0]};
        else
            fit = val;
    end
endmodule

// File: rtl/regbank_storage.sv
// Register storage: A, B and IDX_N word registers with two write ports and
// three combinational read ports. Port 0 has priority over port 1 when
// both hit the same byte. Byte registers read zero-extended; unused codes
// read zero.
module regbank_storage
    import regbank_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                p0_en,
    input  logic [2:0]          p0_sel,
    input  logic [2*BYTE_W-1:0] p0_data,
    input  logic                p1_en,
    input  logic [2:0]          p1_sel,
    input  logic [2*BYTE_W-1:0] p1_data,
    input  logic [2:0]          rd0_sel,
    output logic [2*BYTE_W-1:0] rd0_val,
    input  logic [2:0]          rd1_sel,
    output logic [2*BYTE_W-1:0] rd1_val,
    input  logic [2:0]          rd2_sel,
    output logic [2*BYTE_W-1:0] rd2_val,
    output logic [BYTE_W-1:0]   acc_hi,
    output logic [BYTE_W-1:0]   acc_lo
);
    localparam int WIDE_W = 2 * BYTE_W;
    localparam int IDX_N  = 3;
    localparam int CODES  = 1 << SEL_W;

    logic [BYTE_W-1:0] acc_a, acc_b;
    logic [WIDE_W-1:0] idx_val [IDX_N];
    logic [WIDE_W-1:0] by_code [CODES];

    // Code of word register k: X, Y, ... with the last one being SP.
    function automatic sel_t idx_code(int k);
        if (k == IDX_N - 1) return SEL_SP;
        return SEL_X + sel_t'(k);
    endfunction

    // Accumulator bytes; port 1 first so that port 0 wins a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_a <= '0;
            acc_b <= '0;
        end else begin
            if (p1_en && p1_sel == SEL_A) acc_a <= p1_data[BYTE_W-1:0];
            if (p1_en && p1_sel == SEL_B) acc_b <= p1_data[BYTE_W-1:0];
            if (p1_en && p1_sel == SEL_D) begin
                acc_a <= p1_data[WIDE_W-1:BYTE_W];
                acc_b <= p1_data[BYTE_W-1:0];
            end
            if (p0_en && p0_sel == SEL_A) acc_a <= p0_data[BYTE_W-1:0];
            if (p0_en && p0_sel == SEL_B) acc_b <= p0_data[BYTE_W-1:0];
            if (p0_en && p0_sel == SEL_D) begin
                acc_a <= p0_data[WIDE_W-1:BYTE_W];
                acc_b <= p0_data[BYTE_W-1:0];
            end
        end
    end

    for (genvar k = 0; k < IDX_N; k++) begin : g_idx
        logic [WIDE_W-1:0] q;
        // Word register k, written from whichever port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (p0_en && p0_sel == idx_code(k))
                q <= p0_data;
            else if (p1_en && p1_sel == idx_code(k))
                q <= p1_data;
        end
        assign idx_val[k] = q;
    end

    // Lay out every register by its select code for the read muxes.
    always_comb begin
        for (int c = 0; c < CODES; c++) by_code[c] = '0;
        by_code[SEL_A] = {{BYTE_W{1'b0}}, acc_a};
        by_code[SEL_B] = {{BYTE_W{1'b0}}, acc_b};
        by_code[SEL_D] = {acc_a, acc_b};
        for (int k = 0; k < IDX_N; k++) by_code[idx_code(k)] = idx_val[k];
    end

    assign rd0_val = by_code[rd0_sel];
    assign rd1_val = by_code[rd1_sel];
    assign rd2_val = by_code[rd2_sel];
    assign acc_hi  = acc_a;
    assign acc_lo  = acc_b;
endmodule

// File: rtl/regbank_xfer.sv
// Top of the accumulator register file. Loads, moves, exchanges and A/B
// flag copies complete on the edge where op_valid is high; the answer
// pulses (done or err) and the flag strobe appear in the following cycle.
// Assumes a synchronous active-low reset.
module regbank_xfer
    import regbank_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WIDE_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [2:0]        op_dst,
    input  logic [2:0]        op_src,
    input  logic [WIDE_W-1:0] wr_data,
    input  logic [2:0]        rd_sel,
    output logic [WIDE_W-1:0] rd_data,
    output logic              op_done,
    output logic              op_err,
    output logic              flag_upd,
    output logic              flag_n,
    output logic              flag_z
);
    logic              accept, dst_byte, src_byte;
    logic [WIDE_W-1:0] src_val, dst_val, fit_fwd, fit_back;
    logic              p0_en, p1_en;
    logic [2:0]        p0_sel, p1_sel;
    logic [WIDE_W-1:0] p0_data, p1_data;
    logic [BYTE_W-1:0] acc_hi, acc_lo;
    logic              is_fcopy;

    regbank_decode u_decode (
        .op_kind (op_kind),
        .op_dst  (op_dst),
        .op_src  (op_src),
        .accept  (accept),
        .dst_byte(dst_byte),
        .src_byte(src_byte)
    );

    regbank_fit #(.BYTE_W(BYTE_W)) u_fit_fwd (
        .val      (src_val),
        .from_byte(src_byte),
        .to_byte  (dst_byte),
        .fit      (fit_fwd)
    );

    regbank_fit #(.BYTE_W(BYTE_W)) u_fit_back (
        .val      (dst_val),
        .from_byte(dst_byte),
        .to_byte  (src_byte),
        .fit      (fit_back)
    );

    regbank_storage #(.BYTE_W(BYTE_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .p0_en  (p0_en),
        .p0_sel (p0_sel),
        .p0_data(p0_data),
        .p1_en  (p1_en),
        .p1_sel (p1_sel),
        .p1_data(p1_data),
        .rd0_sel(rd_sel),
        .rd0_val(rd_data),
        .rd1_sel(op_src),
        .rd1_val(src_val),
        .rd2_sel(op_dst),
        .rd2_val(dst_val),
        .acc_hi (acc_hi),
        .acc_lo (acc_lo)
    );

    assign is_fcopy = (op_kind_e'(op_kind) == OP_FCOPY);

    // Route the accepted operation onto the storage write ports.
    always_comb begin
        p0_en   = 1'b0;
        p1_en   = 1'b0;
        p0_sel  = op_dst;
        p1_sel  = op_src;
        p0_data = wr_data;
        p1_data = fit_back;
        if (op_valid && accept) begin
            case (op_kind_e'(op_kind))
                OP_LOAD: p0_en = 1'b1;
                OP_SWAP: begin
                    p0_en   = 1'b1;
                    p1_en   = 1'b1;
                    p0_data = fit_fwd;
                end
                default: begin
                    p0_en   = 1'b1;
                    p0_data = fit_fwd;
                end
            endcase
        end
    end

    // Answer pulses and flag results, one cycle after the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_done  <= 1'b0;
            op_err   <= 1'b0;
            flag_upd <= 1'b0;
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
        end else begin
            op_done  <= op_valid && accept;
            op_err   <= op_valid && !accept;
            flag_upd <= op_valid && accept && is_fcopy;
            if (op_valid && accept && is_fcopy) begin
                flag_n <= src_val[BYTE_W-1];
                flag_z <= (src_val[BYTE_W-1:0] == '0);
            end
        end
    end
endmodule

// File: rtl/regbank_xfer_chk.sv
// Protocol checker for regbank_xfer, attached by bind below.
module regbank_xfer_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_valid,
    input logic [1:0]          op_kind,
    input logic [2:0]          op_dst,
    input logic [2*BYTE_W-1:0] wr_data,
    input logic                op_done,
    input logic                op_err,
    input logic                flag_upd,
    input logic [BYTE_W-1:0]   acc_hi,
    input logic [BYTE_W-1:0]   acc_lo
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (acc_hi == '0 && acc_lo == '0 && !op_done && !op_err && !flag_upd));

    // R2
    load_d_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd0 && op_dst == 3'd3) |=>
        (acc_hi == $past(wr_data[2*BYTE_W-1:BYTE_W]) && acc_lo == $past(wr_data[BYTE_W-1:0])));

    // R8
    reject_holds_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> (acc_hi == $past(acc_hi) && acc_lo == $past(acc_lo)));

    // R9
    answer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_done && op_err));

    // R9
    op_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (op_done || op_err));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!op_done && !op_err));

    // R10
    fupd_only_fcopy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind != 2'd3) |=> !flag_upd);

    // R10
    fupd_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd |-> op_done);
endmodule

bind regbank_xfer regbank_xfer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_valid(op_valid),
    .op_kind (op_kind),
    .op_dst  (op_dst),
    .wr_data (wr_data),
    .op_done (op_done),
    .op_err  (op_err),
    .flag_upd(flag_upd),
    .acc_hi  (acc_hi),
    .acc_lo  (acc_lo)
);

// File: tb/test_regbank_xfer.sv
// Bench for regbank_xfer: directed corners plus seeded random operations,
// compared against a behavioural register model.
module test_regbank_xfer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [2:0]  op_dst = '0, op_src = '0, rd_sel = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        op_done, op_err, flag_upd, flag_n, flag_z;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_a = '0, m_b = '0;
    logic [15:0] m_x = '0, m_y = '0, m_sp = '0;

    regbank_xfer i_regbank_xfer (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_dst(op_dst), .op_src(op_src), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .op_done(op_done), .op_err(op_err),
        .flag_upd(flag_upd), .flag_n(flag_n), .flag_z(flag_z)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic m_valid(logic [2:0] c);
        return c != 3'd2 && c != 3'd6;
    endfunction

    function automatic logic m_isbyte(logic [2:0] c);
        return c == 3'd0 || c == 3'd1;
    endfunction

    function automatic logic [15:0] m_get(logic [2:0] c);
        case (c)
            3'd0: return {8'h00, m_a};
            3'd1: return {8'h00, m_b};
            3'd3: return {m_a, m_b};
            3'd4: return m_x;
            3'd5: return m_y;
            3'd7: return m_sp;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] m_conv(logic [15:0] v, logic fb, logic tb);
        if (tb) return {8'h00, v[7:0]};
        if (fb) return {{8{v[7]}}, v[7:0]};
        return v;
    endfunction

    task automatic m_set(logic [2:0] c, logic [15:0] v);
        case (c)
            3'd0: m_a = v[7:0];
            3'd1: m_b = v[7:0];
            3'd3: begin m_a = v[15:8]; m_b = v[7:0]; end
            3'd4: m_x = v;
            3'd5: m_y = v;
            3'd7: m_sp = v;
            default: ;
        endcase
    endtask

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Read back every register (and one unused code) while idle.
    task automatic check_regs(string tag);
        logic [2:0] codes [7] = '{3'd0, 3'd1, 3'd3, 3'd4, 3'd5, 3'd7, 3'd2};
        for (int i = 0; i < 7; i++) begin
            rd_sel = codes[i];
            #1;
            check(tag, $sformatf("reg code %0d", codes[i]), rd_data, m_get(codes[i]));
        end
    endtask

    task automatic run_op(logic [1:0] kind, logic [2:0] dst, logic [2:0] src,
                          logic [15:0] data, string tag);
        logic        ok = 1'b0, fupd = 1'b0, en = 1'b0, ez = 1'b0;
        logic [15:0] sv = m_get(src), dv = m_get(dst);
        case (kind)
            2'd0: begin ok = m_valid(dst); if (ok) m_set(dst, data); end
            2'd1: begin
                ok = m_valid(dst) && m_valid(src);
                if (ok) m_set(dst, m_conv(sv, m_isbyte(src), m_isbyte(dst)));
            end
            2'd2: begin
                ok = m_valid(dst) && m_valid(src) &&
                     !(dst == 3'd3 && m_isbyte(src)) && !(src == 3'd3 && m_isbyte(dst));
                if (ok) begin
                    m_set(dst, m_conv(sv, m_isbyte(src), m_isbyte(dst)));
                    m_set(src, m_conv(dv, m_isbyte(dst), m_isbyte(src)));
                end
            end
            default: begin
                ok = (dst == 3'd0 && src == 3'd1) || (dst == 3'd1 && src == 3'd0);
                if (ok) begin
                    m_set(dst, sv);
                    fupd = 1'b1;
                    en = sv[7];
                    ez = (sv[7:0] == 8'h00);
                end
            end
        endcase
        @(negedge clk);
        op_valid = 1'b1; op_kind = kind; op_dst = dst; op_src = src; wr_data = data;
        @(negedge clk);
        op_valid = 1'b0;
        check(tag, "op_done", {15'd0, op_done}, {15'd0, ok});
        check(ok ? tag : "R8", "op_err", {15'd0, op_err}, {15'd0, !ok});
        check("R10", "flag_upd", {15'd0, flag_upd}, {15'd0, fupd});
        if (fupd) begin
            check("R10", "flag_n", {15'd0, flag_n}, {15'd0, en});
            check("R10", "flag_z", {15'd0, flag_z}, {15'd0, ez});
        end
        @(negedge clk);
        check("R9", "idle op_done", {15'd0, op_done}, 16'd0);
        check_regs(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed_unused;
        seed_unused = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "op_done", {15'd0, op_done}, 16'd0);
        check("R1", "op_err", {15'd0, op_err}, 16'd0);
        check("R1", "flag_upd", {15'd0, flag_upd}, 16'd0);
        check_regs("R1");
        rst_n = 1'b1;

        run_op(2'd0, 3'd3, 3'd0, 16'hA5C3, "R2");   // D load splits into A:B (R3 read)
        run_op(2'd0, 3'd4, 3'd0, 16'h1234, "R2");
        run_op(2'd0, 3'd1, 3'd0, 16'hFF7E, "R2");   // byte load takes low byte
        run_op(2'd1, 3'd5, 3'd4, 16'h0, "R4");       // X to Y
        run_op(2'd1, 3'd7, 3'd3, 16'h0, "R4");       // D to SP
        run_op(2'd1, 3'd4, 3'd0, 16'h0, "R5");       // A=A5 to X sign-extends
        run_op(2'd1, 3'd5, 3'd1, 16'h0, "R5");       // B=7E to Y positive
        run_op(2'd1, 3'd0, 3'd7, 16'h0, "R6");       // SP low byte to A
        run_op(2'd1, 3'd1, 3'd3, 16'h0, "R6");       // D low byte to B
        run_op(2'd2, 3'd4, 3'd5, 16'h0, "R7");       // X <-> Y
        run_op(2'd0, 3'd0, 3'd0, 16'h0090, "R2");
        run_op(2'd2, 3'd0, 3'd7, 16'h0, "R7");       // A <-> SP mixed sizes
        run_op(2'd1, 3'd2, 3'd4, 16'h0, "R8");       // invalid destination
        run_op(2'd0, 3'd6, 3'd0, 16'hFFFF, "R8");    // invalid load target
        run_op(2'd2, 3'd3, 3'd0, 16'h0, "R8");       // D <-> A rejected
        run_op(2'd3, 3'd4, 3'd0, 16'h0, "R8");       // flag copy with X rejected
        run_op(2'd0, 3'd0, 3'd0, 16'h0000, "R2");
        run_op(2'd3, 3'd1, 3'd0, 16'h0, "R10");      // zero byte: Z set
        run_op(2'd0, 3'd1, 3'd0, 16'h0090, "R2");
        run_op(2'd3, 3'd0, 3'd1, 16'h0, "R10");      // negative byte: N set

        for (int n = 0; n < 400; n++) begin
            logic [1:0] k = 2'($urandom_range(0, 3));
            logic [2:0] d = 3'($urandom_range(0, 7));
            logic [2:0] s = 3'($urandom_range(0, 7));
            logic [15:0] w = 16'($urandom);
            string t;
            case (k)
                2'd0: t = "R2";
                2'd1: t = "R4";
                2'd2: t = "R7";
                default: t = "R10";
            endcase
            run_op(k, d, s, w, t);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule